// File: doc/BRIEF.md
# Configurable Rotate and Shift Unit

This block moves the bits of a W-bit data word by a computed distance. It is purely combinational. There are two control modes. In barrel mode, a binary amount input moves the word toward the most significant end by that many places. In step mode, a two-bit control either leaves the word alone or moves it by exactly one place, to the left or to the right.

A separate static input sets the edge policy. With the policy set to wrap, bits that leave one end come back in at the other end. With the policy set to discard, those bits are lost and the vacated positions read zero. The mode and policy inputs are meant to be held static while the unit is in use.

Inside, a small control module turns the mode inputs into one effective left-rotation distance plus two strobes. The datapath is a bank of per-output-bit multiplexers. Each multiplexer selects among all W candidate source bits and is then masked according to the edge policy.

Top module: `rot_shift_unit`

## Requirements
- R1: With modeBarrel=1 and wrapEn=1, dataOut equals dataIn rotated toward the MSB by shAmt places (for W=8, 8'b11001010 moved by 3 gives 8'b01010110).
- R2: With modeBarrel=1 and wrapEn=0, dataOut equals dataIn shifted toward the MSB by shAmt places, truncated to W bits, with the low shAmt bits at 0.
- R3: In barrel mode, shAmt=0 gives dataOut equal to dataIn under either policy.
- R4: In barrel mode, the distance used is shAmt modulo W. This matters when W is not a power of two (for W=6, shAmt=7 acts as 1).
- R5: With modeBarrel=0 and dirCtl[1]=0, dataOut equals dataIn whatever the values of dirCtl[0], wrapEn and shAmt.
- R6: With modeBarrel=0 and dirCtl=2'b10, dataOut is dataIn moved one place toward the MSB. The LSB receives the old MSB when wrapEn=1, and 0 otherwise.
- R7: With modeBarrel=0 and dirCtl=2'b11, dataOut is dataIn moved one place toward the LSB. The MSB receives the old LSB when wrapEn=1, and 0 otherwise.
- R8: shAmt has no effect in step mode, and dirCtl has no effect in barrel mode.
- R9: With wrapEn=1, the number of ones in dataOut equals the number in dataIn. With wrapEn=0, it is never larger.
- R10: dataOut is a combinational function of the inputs and settles without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | W | Word to be moved |
| modeBarrel | input | 1 | 1: barrel mode using shAmt; 0: step mode using dirCtl |
| wrapEn | input | 1 | 1: bits wrap to the opposite end; 0: bits are lost and zeros fill |
| shAmt | input | $clog2(W) | Barrel distance toward the MSB |
| dirCtl | input | 2 | Step control: bit 1 enables the step; bit 0 selects right (1) or left (0) |
| dataOut | output | W | Moved word |

## Verification
The default 8-bit unit is swept over every data value, every amount and both policies in barrel mode. It is also swept over every data value, every step code and every amount value in step mode. Sweeping every amount against every word separates a wrong source-index in any single multiplexer from a wrong fill mask, because the two faults corrupt different bit positions.

Running the step-mode sweep with the unused amount input varied shows that stray inputs cannot leak through. A second instance with W=6 is rotated by amounts 6 and 7, which exposes a missing modulo reduction.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic rightStep;  // single step toward LSB is active
    logic keepWrap;   // bits wrap instead of being lost
  } stepStrobe_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int W = 8,
  localparam int LG = (W > 1) ? $clog2(W) : 1
) (
  input  logic          modeBarrel,
  input  logic          wrapEn,
  input  logic [LG-1:0] shAmt,
  input  logic [1:0]    dirCtl,
  output logic [LG-1:0] amtEff,
  output stepStrobe_t   strobe
);
  localparam logic [LG-1:0] STEP_LEFT  = LG'(1);
  localparam logic [LG-1:0] STEP_RIGHT = LG'(W - 1);

  logic [LG-1:0] amtMod;
  assign amtMod = LG'(32'(shAmt) % W);

  always_comb begin
    strobe.keepWrap  = wrapEn;
    strobe.rightStep = 1'b0;
    if (modeBarrel) begin
      amtEff = amtMod;
    end else if (!dirCtl[1]) begin
      amtEff = '0;
    end else if (dirCtl[0]) begin
      amtEff = STEP_RIGHT;
      strobe.rightStep = 1'b1;
    end else begin
      amtEff = STEP_LEFT;
    end
  end

  always_comb begin
    // R4
    amt_range_chk: assert (32'(amtEff) < W)
      else $error("effective distance out of range");
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int W = 8,
  localparam int LG = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  dataIn,
  input  logic [LG-1:0] amtEff,
  input  stepStrobe_t   strobe,
  output logic [W-1:0]  dataOut
);
  // One multiplexer per output bit over all W candidate sources
  for (genvar i = 0; i < W; i++) begin : gBit
    logic pick;
    logic keep;
    always_comb begin
      pick = 1'b0;
      for (int j = 0; j < W; j++) begin
        if (amtEff == LG'(j)) pick = dataIn[(i - j + W) % W];
      end
    end
    if (i == W - 1) begin : gTop
      assign keep = strobe.keepWrap |
                    (!strobe.rightStep && (i >= 32'(amtEff)));
    end else begin : gRest
      assign keep = strobe.keepWrap | strobe.rightStep |
                    (i >= 32'(amtEff));
    end
    assign dataOut[i] = pick & keep;
  end

  logic [W-1:0] lowMask;
  assign lowMask = W'((64'(1) << amtEff) - 64'(1));

  always_comb begin
    if (!strobe.keepWrap && !strobe.rightStep) begin
      // R2
      low_fill_chk: assert ((dataOut & lowMask) == '0)
        else $error("vacated low bits not zero");
    end
    if (!strobe.keepWrap && strobe.rightStep) begin
      // R7
      top_fill_chk: assert (dataOut[W-1] == 1'b0)
        else $error("vacated top bit not zero");
    end
  end
endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit
  import rs_pkg::*;
#(
  parameter int W = 8,
  localparam int LG = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  dataIn,
  input  logic          modeBarrel,
  input  logic          wrapEn,
  input  logic [LG-1:0] shAmt,
  input  logic [1:0]    dirCtl,
  output logic [W-1:0]  dataOut
);
  logic [LG-1:0] amtEff;
  stepStrobe_t   strobe;

  rs_ctrl #(.W(W)) uCtrl (
    .modeBarrel(modeBarrel),
    .wrapEn(wrapEn),
    .shAmt(shAmt),
    .dirCtl(dirCtl),
    .amtEff(amtEff),
    .strobe(strobe)
  );

  rs_datapath #(.W(W)) uPath (
    .dataIn(dataIn),
    .amtEff(amtEff),
    .strobe(strobe),
    .dataOut(dataOut)
  );

  always_comb begin
    if (!modeBarrel && !dirCtl[1]) begin
      // R5
      pass_thru_chk: assert (dataOut == dataIn)
        else $error("disabled step changed the word");
    end
    if (wrapEn) begin
      // R9
      wrap_count_chk: assert ($countones(dataOut) == $countones(dataIn))
        else $error("wrap lost or gained bits");
    end else begin
      // R9
      drop_count_chk: assert ($countones(dataOut) <= $countones(dataIn))
        else $error("discard created bits");
    end
  end
endmodule

// File: tb/sim_rot_shift_unit.sv
`timescale 1ns/1ps
module sim_rot_shift_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] dIn = '0;
  logic       mB = 1'b0;
  logic       wE = 1'b0;
  logic [2:0] amt = '0;
  logic [1:0] dc = '0;
  logic [7:0] dOut;

  logic [5:0] dIn6 = '0;
  logic [2:0] amt6 = '0;
  logic [5:0] dOut6;

  rot_shift_unit #(.W(8)) u0 (
    .dataIn(dIn), .modeBarrel(mB), .wrapEn(wE),
    .shAmt(amt), .dirCtl(dc), .dataOut(dOut)
  );

  rot_shift_unit #(.W(6)) u1 (
    .dataIn(dIn6), .modeBarrel(1'b1), .wrapEn(1'b1),
    .shAmt(amt6), .dirCtl(2'b00), .dataOut(dOut6)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic int rotL8(int d, int k);
    int v = (d << k) | (d >> (8 - k));
    return v & 255;
  endfunction

  function automatic int ones(int d);
    int c = 0;
    for (int b = 0; b < 8; b++) c += (d >> b) & 1;
    return c;
  endfunction

  initial begin
    #1;
    chk("R10 idle zero", int'(dOut), 0);
    // R1 worked example
    dIn = 8'hCA; mB = 1'b1; wE = 1'b1; amt = 3'd3; #1;
    chk("R1 example", int'(dOut), 8'h56);
    // R10: output follows input with no clock edge
    dIn = 8'h01; #0.5;
    chk("R10 no clock", int'(dOut), 8'h08);

    // Barrel sweep
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 256; d++)
        for (int k = 0; k < 8; k++) begin
          int exp;
          mB = 1'b1; wE = w[0]; dIn = d[7:0]; amt = k[2:0];
          dc = 2'(d + k);  // R8: dirCtl varied in barrel mode
          #1;
          exp = w ? rotL8(d, k) : ((d << k) & 255);
          if (k == 0) chk("R3", int'(dOut), d);
          else if (w) chk("R1 R8", int'(dOut), exp);
          else chk("R2 R8", int'(dOut), exp);
          if (w) chk("R9 wrap", ones(int'(dOut)), ones(d));
          else chk("R9 drop", int'(ones(int'(dOut)) <= ones(d)), 1);
        end

    // Step sweep
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 256; d++)
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 8; k++) begin
            int exp;
            mB = 1'b0; wE = w[0]; dIn = d[7:0]; dc = c[1:0]; amt = k[2:0];
            #1;
            if (c < 2) begin
              chk("R5 R8", int'(dOut), d);
            end else if (c == 2) begin
              exp = ((d << 1) & 255) | (w ? (d >> 7) : 0);
              chk("R6 R8", int'(dOut), exp);
            end else begin
              exp = (d >> 1) | (w ? ((d & 1) << 7) : 0);
              chk("R7 R8", int'(dOut), exp);
            end
          end

    // Modulo distance on a 6-bit instance
    for (int d = 0; d < 64; d++)
      for (int k = 0; k < 8; k++) begin
        int r, exp;
        dIn6 = d[5:0]; amt6 = k[2:0]; #1;
        r = k % 6;
        exp = ((d << r) | (d >> (6 - r))) & 63;
        if (k >= 6) chk("R4", int'(dOut6), exp);
        else chk("R1 w6", int'(dOut6), exp);
      end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule